// File: doc/BRIEF.md
# Star-Routed Test Access Hub

This block sits between a test host and several devices under test. Each device is wired to the hub by a single bidirectional test line of its own, so the devices form a star around the hub and never share a scan path. The host sends a serial packet on `tdi`, and `tdi_en` marks each cycle that carries a valid bit. The packet opens with an address header, sent most significant bit first. The hub shifts the header in, latches the address, and from then on steers the payload bits onto the addressed line only. All other lines stay high-impedance.

After the last payload bit the hub spends one cycle showing that bit and then releases the line. It then samples the same line for a fixed number of cycles and returns each sampled bit to the host on `tdo`, with `tdo_valid` high. The address stays latched after the response. Later packets therefore carry no header: every bit they hold is payload for the same device. To address another device the host pulls `trst_n` low, which clears the selection and the sequencer at once, and then sends a packet with a new header.

Top module: `star_test_hub`

## Requirements
- R1: The first ADDR_W accepted bits after reset or test reset form the device address, most significant bit first. From the cycle after the last header bit is accepted, `sel_valid` is high and `sel_addr` holds that address.
- R2: Each accepted payload bit appears on the addressed device line in the cycle after it is accepted. It stays there until the next accepted payload bit replaces it. Payload bit order is preserved.
- R3: At any time at most one bit of `line_drive` is high, and only the bit at index `sel_addr`. Every line whose `line_drive` bit is low is left high-impedance by the hub.
- R4: The hub drives the line for one more cycle after accepting the final payload bit (PAY_LEN bits in total). From the next cycle on it leaves the line undriven and samples it on RSP_LEN consecutive clock edges. Each sample appears on `tdo` one cycle after it is taken, with `tdo_valid` high. `tdo` is low whenever `tdo_valid` is low.
- R5: A cycle with `tdi_en` low accepts no bit. While no address is selected, toggling `tdi` with `tdi_en` low drives no line and produces no response.
- R6: Once a response has finished, the address stays selected. The next packet has no header, and all of its accepted bits are payload for the same device.
- R7: `trst_n` low clears the selection, the line drive, `tdo` and `tdo_valid` without waiting for a clock edge. The first packet after it begins with a header.
- R8: During the turnaround cycle and the response cycles, `tdi_en` and `tdi` are ignored. They neither lengthen nor restart the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Hub clock |
| trst_n | input | 1 | Test reset, active low, asynchronous |
| tdi | input | 1 | Serial packet bit from the host |
| tdi_en | input | 1 | High when `tdi` carries a bit to accept |
| tdo | output | 1 | Serial response bit to the host |
| tdo_valid | output | 1 | High when `tdo` carries a response bit |
| sel_valid | output | 1 | High when an address is latched |
| sel_addr | output | ADDR_W | Latched device address |
| line_drive | output | N_DEV | One bit per device line, high while the hub drives it |
| dut_io | inout | N_DEV | Bidirectional test line, one per device |

## Verification
A phase counter that is off by one shows at the ports within a packet. It either cuts the payload short or lets the drive overlap the first response cycle, and it shifts every `tdo` bit by one position. A header register that shifts in the wrong order, or drops a bit, steers the whole payload onto a neighbouring line. This is visible from the first payload cycle through `line_drive` and through the line values. A selection that is not cleared, or not kept, shows in the first packet after a test reset, or in the first packet that carries no header.

// File: rtl/star_hub_pkg.sv
package star_hub_pkg;

  typedef enum logic [2:0] {
    HS_IDLE,
    HS_HDR,
    HS_PAY,
    HS_TURN,
    HS_RSP,
    HS_HOLD
  } hub_state_e;

  // bits needed to count 0 .. n-1, never below one
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/star_hdr_latch.sv
module star_hdr_latch
  import star_hub_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              trst_n,
  input  logic              take,
  input  logic              bit_in,
  output logic              done,
  output logic [ADDR_W-1:0] addr_q,
  output logic              addr_vld
);
  localparam int unsigned HC_W = cnt_width(ADDR_W);

  logic [ADDR_W-1:0] sr_q;
  logic [HC_W-1:0]   hcnt_q;
  logic [ADDR_W-1:0] sr_nxt;

  assign sr_nxt = ADDR_W'({sr_q, bit_in});
  assign done   = take && (hcnt_q == HC_W'(ADDR_W - 1));

  always_ff @(posedge clk or negedge trst_n) begin
    if (!trst_n) begin
      sr_q     <= '0;
      hcnt_q   <= '0;
      addr_q   <= '0;
      addr_vld <= 1'b0;
    end else if (take) begin
      if (done) begin
        addr_q   <= sr_nxt;
        addr_vld <= 1'b1;
        sr_q     <= '0;
        hcnt_q   <= '0;
      end else begin
        sr_q   <= sr_nxt;
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/star_phase_seq.sv
module star_phase_seq
  import star_hub_pkg::*;
#(
  parameter int unsigned PAY_LEN = 8,
  parameter int unsigned RSP_LEN = 8
) (
  input  logic       clk,
  input  logic       trst_n,
  input  logic       tdi_en,
  input  logic       hdr_done,
  output hub_state_e state,
  output logic       hdr_take,
  output logic       pay_take,
  output logic       rsp_take,
  output logic       pay_last,
  output logic       rsp_last
);
  localparam int unsigned CNT_W = cnt_width(max2(PAY_LEN, RSP_LEN));

  hub_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign state    = st_q;
  assign hdr_take = tdi_en && ((st_q == HS_IDLE) || (st_q == HS_HDR));
  assign pay_take = tdi_en && ((st_q == HS_PAY) || (st_q == HS_HOLD));
  assign rsp_take = (st_q == HS_RSP);
  assign pay_last = pay_take && (cnt_q == CNT_W'(PAY_LEN - 1));
  assign rsp_last = rsp_take && (cnt_q == CNT_W'(RSP_LEN - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      HS_IDLE, HS_HDR: begin
        if (hdr_done)      st_d = HS_PAY;
        else if (hdr_take) st_d = HS_HDR;
      end
      HS_PAY, HS_HOLD: begin
        if (pay_last) begin
          st_d  = HS_TURN;
          cnt_d = '0;
        end else if (pay_take) begin
          st_d  = HS_PAY;
          cnt_d = cnt_q + 1'b1;
        end
      end
      HS_TURN: begin
        st_d  = HS_RSP;
        cnt_d = '0;
      end
      HS_RSP: begin
        if (rsp_last) begin
          st_d  = HS_HOLD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d  = HS_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge trst_n) begin
    if (!trst_n) begin
      st_q  <= HS_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/star_line_port.sv
module star_line_port #(
  parameter int unsigned N_DEV = 4
) (
  input  logic [N_DEV-1:0] drive_mask,
  input  logic             drive_bit,
  output logic [N_DEV-1:0] line_in,
  inout  wire  [N_DEV-1:0] pins
);
  for (genvar g = 0; g < N_DEV; g++) begin : g_line
    assign pins[g]    = drive_mask[g] ? drive_bit : 1'bz;
    assign line_in[g] = pins[g];
  end
endmodule

// File: rtl/star_test_hub.sv
module star_test_hub
  import star_hub_pkg::*;
#(
  parameter int unsigned N_DEV   = 4,
  parameter int unsigned ADDR_W  = cnt_width(N_DEV),
  parameter int unsigned PAY_LEN = 8,
  parameter int unsigned RSP_LEN = 8
) (
  input  logic              clk,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              tdi_en,
  output logic              tdo,
  output logic              tdo_valid,
  output logic              sel_valid,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [N_DEV-1:0]  line_drive,
  inout  wire  [N_DEV-1:0]  dut_io
);
  // address to one-hot line mask; addresses past N_DEV select nothing
  function automatic logic [N_DEV-1:0] dev_mask(input logic [ADDR_W-1:0] a);
    logic [N_DEV-1:0] m;
    m = '0;
    for (int i = 0; i < N_DEV; i++) m[i] = (a == ADDR_W'(i));
    return m;
  endfunction

  function automatic logic pick_line(input logic [N_DEV-1:0] v, input logic [ADDR_W-1:0] a);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N_DEV; i++) if (a == ADDR_W'(i)) r = v[i];
    return r;
  endfunction

  // named internal events, also used by the bound checker
  hub_state_e        state_w;
  logic              hdr_take_w, hdr_done_w;
  logic              pay_take_w, rsp_take_w;
  logic              pay_last_w, rsp_last_w;
  logic [ADDR_W-1:0] addr_w;
  logic              addr_vld_w;
  logic [N_DEV-1:0]  line_in_w;

  logic drv_on_q, drv_bit_q;
  logic tdo_q, tdo_vld_q;

  star_hdr_latch #(.ADDR_W(ADDR_W)) u_hdr (
    .clk      (clk),
    .trst_n   (trst_n),
    .take     (hdr_take_w),
    .bit_in   (tdi),
    .done     (hdr_done_w),
    .addr_q   (addr_w),
    .addr_vld (addr_vld_w)
  );

  star_phase_seq #(.PAY_LEN(PAY_LEN), .RSP_LEN(RSP_LEN)) u_seq (
    .clk      (clk),
    .trst_n   (trst_n),
    .tdi_en   (tdi_en),
    .hdr_done (hdr_done_w),
    .state    (state_w),
    .hdr_take (hdr_take_w),
    .pay_take (pay_take_w),
    .rsp_take (rsp_take_w),
    .pay_last (pay_last_w),
    .rsp_last (rsp_last_w)
  );

  // drive register: set by each payload bit, held through the payload
  // phase, dropped one cycle after the final bit (turnaround)
  always_ff @(posedge clk or negedge trst_n) begin
    if (!trst_n) begin
      drv_on_q  <= 1'b0;
      drv_bit_q <= 1'b0;
    end else begin
      if (pay_take_w) begin
        drv_on_q  <= 1'b1;
        drv_bit_q <= tdi;
      end else if (state_w != HS_PAY) begin
        drv_on_q  <= 1'b0;
      end
    end
  end

  // return path: sample the released line during the response phase
  always_ff @(posedge clk or negedge trst_n) begin
    if (!trst_n) begin
      tdo_q     <= 1'b0;
      tdo_vld_q <= 1'b0;
    end else begin
      tdo_q     <= rsp_take_w ? pick_line(line_in_w, addr_w) : 1'b0;
      tdo_vld_q <= rsp_take_w;
    end
  end

  assign line_drive = (drv_on_q && addr_vld_w) ? dev_mask(addr_w) : '0;

  star_line_port #(.N_DEV(N_DEV)) u_port (
    .drive_mask (line_drive),
    .drive_bit  (drv_bit_q),
    .line_in    (line_in_w),
    .pins       (dut_io)
  );

  assign tdo       = tdo_q;
  assign tdo_valid = tdo_vld_q;
  assign sel_valid = addr_vld_w;
  assign sel_addr  = addr_w;

endmodule

// File: rtl/star_hub_chk.sv
module star_hub_chk #(
  parameter int unsigned N_DEV  = 4,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              trst_n,
  input logic [N_DEV-1:0]  line_drive,
  input logic              sel_valid,
  input logic [ADDR_W-1:0] sel_addr,
  input logic              tdo,
  input logic              tdo_valid,
  input logic              rsp_take
);
  assert_one_line_R3: assert property (@(posedge clk) disable iff (!trst_n)
    $onehot0(line_drive));

  assert_drive_addressed_R3: assert property (@(posedge clk) disable iff (!trst_n)
    (|line_drive) |-> (sel_valid && line_drive[sel_addr]));

  assert_sel_kept_R6: assert property (@(posedge clk) disable iff (!trst_n)
    sel_valid |=> (sel_valid && $stable(sel_addr)));

  assert_released_when_sampled_R4: assert property (@(posedge clk) disable iff (!trst_n)
    tdo_valid |-> (line_drive == '0));

  assert_tdo_quiet_R4: assert property (@(posedge clk) disable iff (!trst_n)
    !tdo_valid |-> !tdo);

  assert_tdo_from_sample_R8: assert property (@(posedge clk) disable iff (!trst_n)
    tdo_valid |-> $past(rsp_take));
endmodule

bind star_test_hub star_hub_chk #(.N_DEV(N_DEV), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .trst_n     (trst_n),
  .line_drive (line_drive),
  .sel_valid  (sel_valid),
  .sel_addr   (sel_addr),
  .tdo        (tdo),
  .tdo_valid  (tdo_valid),
  .rsp_take   (rsp_take_w)
);

// File: tb/star_test_hub_tb.sv
module star_test_hub_tb;
  localparam int N = 4;
  localparam int AW = 2;
  localparam int P = 8;
  localparam int R = 8;

  logic clk = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0;
  logic tdi_en = 1'b0;
  logic tdo, tdo_valid, sel_valid;
  logic [AW-1:0] sel_addr;
  logic [N-1:0] line_drive;
  logic [N-1:0] dev_oe = '0;
  logic [N-1:0] dev_val = '0;
  wire  [N-1:0] dut_io;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [AW-1:0] exp_addr = '0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_dev
    assign dut_io[g] = dev_oe[g] ? dev_val[g] : 1'bz;
  end

  star_test_hub #(.N_DEV(N), .ADDR_W(AW), .PAY_LEN(P), .RSP_LEN(R)) u_dut (
    .clk(clk), .trst_n(trst_n), .tdi(tdi), .tdi_en(tdi_en),
    .tdo(tdo), .tdo_valid(tdo_valid), .sel_valid(sel_valid),
    .sel_addr(sel_addr), .line_drive(line_drive), .dut_io(dut_io)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // {trst_first, header, noise, addr[1:0], payload[7:0], response[7:0]}
  localparam int NV = 6;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 2'd2, 8'hA5, 8'h3C},
    {1'b0, 1'b0, 1'b1, 2'd2, 8'h0F, 8'hF0},
    {1'b1, 1'b1, 1'b0, 2'd0, 8'hFF, 8'h81},
    {1'b1, 1'b1, 1'b1, 2'd3, 8'h00, 8'hFF},
    {1'b0, 1'b0, 1'b0, 2'd3, 8'h5A, 8'hA5},
    {1'b1, 1'b1, 1'b0, 2'd1, 8'hC3, 8'h5A}
  };

  task automatic pulse_trst();
    @(negedge clk);
    trst_n = 1'b0;
    #1;
    chk("R7 sel_valid", 32'(sel_valid), 0);
    chk("R7 line_drive", 32'(line_drive), 0);
    chk("R7 tdo_valid", 32'(tdo_valid), 0);
    @(negedge clk);
    trst_n = 1'b1;
  endtask

  task automatic run_pkt(input logic hdr, input logic noise,
                         input logic [P-1:0] pay, input logic [R-1:0] rsp);
    int off;
    off = hdr ? AW : 0;
    for (int t = 0; t < off + P + R + 3; t++) begin
      @(negedge clk);
      // outputs here reflect edges up to t-1
      if (hdr && t == off) begin
        chk("R1 sel_valid", 32'(sel_valid), 1);
        chk("R1 sel_addr", 32'(sel_addr), 32'(exp_addr));
      end
      if (t >= off + 1 && t <= off + P) begin
        chk("R3 line_drive", 32'(line_drive), 32'(1) << exp_addr);
        chk("R2 line value", 32'(dut_io[exp_addr]), 32'(pay[P - (t - off)]));
      end
      if (t == off + P + 1) chk("R4 released", 32'(line_drive), 0);
      if (t >= off + P + 2 && t <= off + P + R + 1) begin
        chk("R4 tdo_valid", 32'(tdo_valid), 1);
        chk("R4 tdo bit", 32'(tdo), 32'(rsp[R - 1 - (t - off - P - 2)]));
      end
      if (t == off + P + R + 2) begin
        chk("R8 tdo_valid end", 32'(tdo_valid), 0);
        chk("R8 no drive end", 32'(line_drive), 0);
        chk("R6 sel kept", 32'({sel_valid, sel_addr}), 32'({1'b1, exp_addr}));
      end
      // drive inputs for edge t
      tdi_en = 1'b0;
      tdi = 1'b0;
      dev_oe = '0;
      if (hdr && t < AW) begin
        tdi_en = 1'b1;
        tdi = exp_addr[AW - 1 - t];
      end
      if (t >= off && t < off + P) begin
        tdi_en = 1'b1;
        tdi = pay[P - 1 - (t - off)];
      end
      if (noise && t >= off + P && t <= off + P + R) begin
        tdi_en = 1'b1;
        tdi = t[0];
      end
      if (t >= off + P + 1 && t <= off + P + R) begin
        dev_oe[exp_addr] = 1'b1;
        dev_val[exp_addr] = rsp[R - 1 - (t - off - P - 1)];
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset sel_valid", 32'(sel_valid), 0);
    chk("R7 reset line_drive", 32'(line_drive), 0);
    chk("R7 reset tdo", 32'({tdo, tdo_valid}), 0);
    trst_n = 1'b1;

    // R5: bits with tdi_en low are not accepted
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      tdi_en = 1'b0;
      tdi = k[0];
    end
    @(negedge clk);
    chk("R5 no selection", 32'(sel_valid), 0);
    chk("R5 no drive", 32'(line_drive), 0);
    chk("R5 no response", 32'(tdo_valid), 0);

    // vector table: R1, R2, R3, R4, R6, R8
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][20]) pulse_trst();
      if (VEC[v][19]) exp_addr = VEC[v][17:16];
      run_pkt(VEC[v][19], VEC[v][18], VEC[v][15:8], VEC[v][7:0]);
    end

    // R7: test reset in the middle of a payload releases the line at once
    pulse_trst();
    exp_addr = 2'd1;
    for (int t = 0; t < AW + 3; t++) begin
      @(negedge clk);
      tdi_en = 1'b1;
      tdi = (t < AW) ? exp_addr[AW - 1 - t] : 1'b1;
    end
    @(negedge clk);
    tdi_en = 1'b0;
    chk("R2 mid payload drive", 32'(line_drive), 32'b0010);
    trst_n = 1'b0;
    #1;
    chk("R7 async drive clear", 32'(line_drive), 0);
    chk("R7 async sel clear", 32'(sel_valid), 0);
    @(negedge clk);
    trst_n = 1'b1;

    // R7: next packet starts with a header again
    exp_addr = 2'd3;
    run_pkt(1'b1, 1'b0, 8'h96, 8'h69);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule